// File: doc/BRIEF.md
# Stack and Control-Transfer Address Unit

This unit sits beside the execute stage of a small 64-bit processor. For every control-flow or stack instruction it works out the data-memory request and the architectural updates. Those updates are the new stack pointer, the next program counter and, for a pop, the register write. The memory and the register file stay outside the unit. The unit issues a single-word read or write request. The external memory answers it in the same cycle with read data and an error flag.

The unit is a two-stage pipeline and accepts one instruction per cycle. The issue stage decodes the instruction and does the pointer arithmetic. It registers the memory request, so the request is visible in the cycle after the instruction is presented. The commit stage combines the memory reply with the saved context and registers the results one cycle later. Jump and call targets are absolute addresses. The stack grows toward lower addresses, and the stack pointer always addresses the top element.

Top module: `stack_xfer_unit`

## Requirements
- R1: During and after a synchronous active-high reset, every request and result output reads zero until an instruction is issued.
- R2: Push (code 0xA, function 0) requests a write of the rA value at stack pointer minus 8 in the cycle after issue. One cycle later it reports that decremented pointer as the new stack pointer.
- R3: Pop (code 0xB, function 0) requests a read at the unchanged stack pointer. One cycle later it writes the returned word to register rA and reports the stack pointer plus 8.
- R4: When pop names register 4 (the stack pointer) as rA, the new stack pointer is the returned word, and no separate register write is requested.
- R5: Call (code 0x8, function 0) writes the next sequential PC at stack pointer minus 8. It reports that pointer as the new stack pointer and the absolute destination as the next PC.
- R6: Ret (code 0x9, function 0) reads at the stack pointer. It reports the returned word as the next PC and the stack pointer plus 8 as the new stack pointer.
- R7: Jump (code 0x7) with function 0 always selects the absolute destination. With functions 1 to 6 it selects the destination when the condition input is high and the next sequential PC otherwise. A jump makes no memory request and leaves the stack pointer unchanged.
- R8: A memory error reported during the request of a push, pop, call or ret gives status 3 (bad address). It suppresses the stack-pointer, PC and register updates.
- R9: An opcode outside 0x7 to 0xB, a jump function above 6, or a nonzero function on any other code gives status 4 (invalid). It makes no request and no update.
- R10: Every issued instruction produces exactly one result cycle, two clock edges after issue. A completed instruction reports status 1 (normal). Idle cycles report status 0.
- R11: Instructions may be issued on consecutive cycles, and their results come back in issue order with no interference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 4 | Instruction code |
| in_fn | input | 4 | Function code |
| in_sp | input | 64 | Current stack pointer |
| in_ra_id | input | 4 | Register number named as rA |
| in_ra_val | input | 64 | Value of rA |
| in_dest | input | 64 | Absolute destination constant |
| in_next_pc | input | 64 | Address of the following instruction |
| in_cond | input | 1 | Condition for a conditional jump is true |
| mem_rdata | input | 64 | Memory read data for the current request |
| mem_err | input | 1 | Memory reports a bad address for the current request |
| req_addr | output | 64 | Memory request address |
| req_rd | output | 1 | Read request strobe |
| req_wr | output | 1 | Write request strobe |
| req_wdata | output | 64 | Write data |
| res_valid | output | 1 | Result cycle for one instruction |
| res_status | output | 3 | 0 idle, 1 normal, 3 bad address, 4 invalid |
| res_sp_we | output | 1 | Update the stack pointer |
| res_sp | output | 64 | New stack pointer |
| res_pc_we | output | 1 | Redirect the PC |
| res_pc | output | 64 | Next PC |
| res_reg_we | output | 1 | Write a register |
| res_reg_id | output | 4 | Register to write |
| res_reg_data | output | 64 | Value to write |

## Verification
The assertions assume that the memory answers each request in the cycle in which the request is visible. They also assume that mem_rdata and mem_err are meaningful only while a strobe is high. The bench's memory model is a combinational function of req_addr and the strobes: any address whose top nibble is 0xF returns an error. The unit therefore never sees a late or unsolicited reply. The stimulus covers stack pointers near zero, so that the decrement wraps into the error region, and pointers inside that region. It also covers every opcode value and function code, which keeps each error path reachable while respecting the one-cycle reply contract.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_JUMP, K_CALL, K_RET, K_PUSH, K_POP, K_BAD
  } kind_t;

  localparam logic [3:0] OP_JUMP = 4'h7;
  localparam logic [3:0] OP_CALL = 4'h8;
  localparam logic [3:0] OP_RET  = 4'h9;
  localparam logic [3:0] OP_PUSH = 4'hA;
  localparam logic [3:0] OP_POP  = 4'hB;
  localparam logic [3:0] JUMP_FN_MAX = 4'd6;

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_OK   = 3'd1;
  localparam logic [2:0] ST_ADR  = 3'd3;
  localparam logic [2:0] ST_INS  = 3'd4;

  function automatic logic uses_stack(kind_t k);
    return (k == K_CALL) || (k == K_RET) || (k == K_PUSH) || (k == K_POP);
  endfunction
endpackage

// File: rtl/sxu_decode.sv
module sxu_decode
  import sxu_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] op,
  input  logic [3:0] fn,
  output kind_t      kind
);
  always_comb begin
    kind = K_NONE;
    if (valid) begin
      case (op)
        OP_JUMP: kind = (fn <= JUMP_FN_MAX) ? K_JUMP : K_BAD;
        OP_CALL: kind = (fn == 4'd0) ? K_CALL : K_BAD;
        OP_RET:  kind = (fn == 4'd0) ? K_RET  : K_BAD;
        OP_PUSH: kind = (fn == 4'd0) ? K_PUSH : K_BAD;
        OP_POP:  kind = (fn == 4'd0) ? K_POP  : K_BAD;
        default: kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sxu_issue.sv
module sxu_issue
  import sxu_pkg::*;
#(
  parameter int W    = 64,
  parameter int RW   = 4,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  kind_t         kind,
  input  logic [3:0]    fn,
  input  logic [W-1:0]  sp,
  input  logic [RW-1:0] ra_id,
  input  logic [W-1:0]  ra_val,
  input  logic [W-1:0]  dest,
  input  logic [W-1:0]  next_pc,
  input  logic          cond,
  output logic [W-1:0]  req_addr,
  output logic          req_rd,
  output logic          req_wr,
  output logic [W-1:0]  req_wdata,
  output kind_t         s_kind,
  output logic [W-1:0]  s_sp,
  output logic [W-1:0]  s_pc,
  output logic [RW-1:0] s_rid
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] sp_dn, sp_up;
  logic [W-1:0] a_n, wd_n, sp_n, pc_n;
  logic         rd_n, wr_n;

  assign sp_dn = sp - STEP_V;
  assign sp_up = sp + STEP_V;

  always_comb begin
    a_n = '0; wd_n = '0; sp_n = '0; pc_n = '0; rd_n = 1'b0; wr_n = 1'b0;
    case (kind)
      K_PUSH: begin a_n = sp_dn; wr_n = 1'b1; wd_n = ra_val; sp_n = sp_dn; end
      K_CALL: begin a_n = sp_dn; wr_n = 1'b1; wd_n = next_pc; sp_n = sp_dn; pc_n = dest; end
      K_POP:  begin a_n = sp; rd_n = 1'b1; sp_n = sp_up; end
      K_RET:  begin a_n = sp; rd_n = 1'b1; sp_n = sp_up; end
      K_JUMP: pc_n = (fn == 4'd0 || cond) ? dest : next_pc;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_addr <= '0; req_rd <= 1'b0; req_wr <= 1'b0; req_wdata <= '0;
      s_kind <= K_NONE; s_sp <= '0; s_pc <= '0; s_rid <= '0;
    end else begin
      req_addr <= a_n; req_rd <= rd_n; req_wr <= wr_n; req_wdata <= wd_n;
      s_kind <= kind; s_sp <= sp_n; s_pc <= pc_n;
      s_rid <= (kind == K_POP) ? ra_id : '0;
    end
  end
endmodule

// File: rtl/sxu_commit.sv
module sxu_commit
  import sxu_pkg::*;
#(
  parameter int W     = 64,
  parameter int RW    = 4,
  parameter int SP_ID = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  kind_t         s_kind,
  input  logic [W-1:0]  s_sp,
  input  logic [W-1:0]  s_pc,
  input  logic [RW-1:0] s_rid,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_err,
  output logic          res_valid,
  output logic [2:0]    res_status,
  output logic          res_sp_we,
  output logic [W-1:0]  res_sp,
  output logic          res_pc_we,
  output logic [W-1:0]  res_pc,
  output logic          res_reg_we,
  output logic [RW-1:0] res_reg_id,
  output logic [W-1:0]  res_reg_data
);
  localparam logic [RW-1:0] SP_REG = RW'(SP_ID);

  logic bad_adr, ok, pop_sp, sp_w, pc_w, rg_w;

  assign bad_adr = uses_stack(s_kind) && mem_err;
  assign ok      = (s_kind != K_NONE) && (s_kind != K_BAD) && !bad_adr;
  assign pop_sp  = (s_kind == K_POP) && (s_rid == SP_REG);
  assign sp_w    = ok && uses_stack(s_kind);
  assign pc_w    = ok && (s_kind == K_JUMP || s_kind == K_CALL || s_kind == K_RET);
  assign rg_w    = ok && (s_kind == K_POP) && !pop_sp;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; res_status <= ST_IDLE;
      res_sp_we <= 1'b0; res_sp <= '0; res_pc_we <= 1'b0; res_pc <= '0;
      res_reg_we <= 1'b0; res_reg_id <= '0; res_reg_data <= '0;
    end else begin
      res_valid  <= (s_kind != K_NONE);
      res_status <= (s_kind == K_NONE) ? ST_IDLE :
                    (s_kind == K_BAD)  ? ST_INS  :
                    bad_adr            ? ST_ADR  : ST_OK;
      res_sp_we    <= sp_w;
      res_sp       <= !sp_w ? '0 : (pop_sp ? mem_rdata : s_sp);
      res_pc_we    <= pc_w;
      res_pc       <= !pc_w ? '0 : ((s_kind == K_RET) ? mem_rdata : s_pc);
      res_reg_we   <= rg_w;
      res_reg_id   <= rg_w ? s_rid : '0;
      res_reg_data <= rg_w ? mem_rdata : '0;
    end
  end
endmodule

// File: rtl/stack_xfer_unit.sv
module stack_xfer_unit
  import sxu_pkg::*;
#(
  parameter int W     = 64,
  parameter int RW    = 4,
  parameter int STEP  = 8,
  parameter int SP_ID = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    in_op,
  input  logic [3:0]    in_fn,
  input  logic [W-1:0]  in_sp,
  input  logic [RW-1:0] in_ra_id,
  input  logic [W-1:0]  in_ra_val,
  input  logic [W-1:0]  in_dest,
  input  logic [W-1:0]  in_next_pc,
  input  logic          in_cond,
  input  logic [W-1:0]  mem_rdata,
  input  logic          mem_err,
  output logic [W-1:0]  req_addr,
  output logic          req_rd,
  output logic          req_wr,
  output logic [W-1:0]  req_wdata,
  output logic          res_valid,
  output logic [2:0]    res_status,
  output logic          res_sp_we,
  output logic [W-1:0]  res_sp,
  output logic          res_pc_we,
  output logic [W-1:0]  res_pc,
  output logic          res_reg_we,
  output logic [RW-1:0] res_reg_id,
  output logic [W-1:0]  res_reg_data
);
  kind_t         kind, s_kind;
  logic [W-1:0]  s_sp, s_pc;
  logic [RW-1:0] s_rid;

  sxu_decode u_dec (.valid(in_valid), .op(in_op), .fn(in_fn), .kind(kind));

  sxu_issue #(.W(W), .RW(RW), .STEP(STEP)) u_iss (
    .clk(clk), .rst(rst), .kind(kind), .fn(in_fn), .sp(in_sp),
    .ra_id(in_ra_id), .ra_val(in_ra_val), .dest(in_dest),
    .next_pc(in_next_pc), .cond(in_cond),
    .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
    .s_kind(s_kind), .s_sp(s_sp), .s_pc(s_pc), .s_rid(s_rid));

  sxu_commit #(.W(W), .RW(RW), .SP_ID(SP_ID)) u_com (
    .clk(clk), .rst(rst), .s_kind(s_kind), .s_sp(s_sp), .s_pc(s_pc),
    .s_rid(s_rid), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .res_valid(res_valid), .res_status(res_status),
    .res_sp_we(res_sp_we), .res_sp(res_sp),
    .res_pc_we(res_pc_we), .res_pc(res_pc),
    .res_reg_we(res_reg_we), .res_reg_id(res_reg_id), .res_reg_data(res_reg_data));
endmodule

// File: rtl/stack_xfer_unit_chk.sv
module stack_xfer_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         req_rd,
  input logic         req_wr,
  input logic [W-1:0] req_addr,
  input logic         mem_err,
  input logic         res_valid,
  input logic [2:0]   res_status,
  input logic         res_sp_we,
  input logic [W-1:0] res_sp,
  input logic         res_pc_we,
  input logic         res_reg_we
);
  // R8
  adr_blocks_updates_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 3'd3) |-> (!res_sp_we && !res_pc_we && !res_reg_we));

  // R8
  err_gives_adr_chk: assert property (@(posedge clk) disable iff (rst)
    ((req_rd || req_wr) && mem_err) |=> (res_valid && res_status == 3'd3));

  // R10
  request_completes_chk: assert property (@(posedge clk) disable iff (rst)
    (req_rd || req_wr) |=> res_valid);

  // R2
  write_sp_matches_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_wr && !mem_err) |=> (res_sp_we && res_sp == $past(req_addr)));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_rd, req_wr}));

  // R10
  idle_status_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_status == 3'd0 && !res_sp_we && !res_pc_we && !res_reg_we));
endmodule

bind stack_xfer_unit stack_xfer_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
  .mem_err(mem_err), .res_valid(res_valid), .res_status(res_status),
  .res_sp_we(res_sp_we), .res_sp(res_sp), .res_pc_we(res_pc_we),
  .res_reg_we(res_reg_we));

// File: tb/stack_xfer_unit_test.sv
module stack_xfer_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_cond = 0;
  logic [3:0] in_op = 0, in_fn = 0, in_ra_id = 0;
  logic [W-1:0] in_sp = 0, in_ra_val = 0, in_dest = 0, in_next_pc = 0;
  logic [W-1:0] mem_rdata;
  logic mem_err;
  logic [W-1:0] req_addr, req_wdata, res_sp, res_pc, res_reg_data;
  logic req_rd, req_wr, res_valid, res_sp_we, res_pc_we, res_reg_we;
  logic [2:0] res_status;
  logic [3:0] res_reg_id;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_xfer_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_fn(in_fn),
    .in_sp(in_sp), .in_ra_id(in_ra_id), .in_ra_val(in_ra_val), .in_dest(in_dest),
    .in_next_pc(in_next_pc), .in_cond(in_cond), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
    .res_valid(res_valid), .res_status(res_status), .res_sp_we(res_sp_we), .res_sp(res_sp),
    .res_pc_we(res_pc_we), .res_pc(res_pc), .res_reg_we(res_reg_we),
    .res_reg_id(res_reg_id), .res_reg_data(res_reg_data));

  function automatic logic [W-1:0] mem_word(logic [W-1:0] a);
    return {a[31:0] ^ 32'h5A5A_0F0F, a[63:32] + 32'h1357_9BDF};
  endfunction
  function automatic logic mem_bad(logic [W-1:0] a);
    return a[63:60] == 4'hF;
  endfunction

  // memory responds within the request cycle
  assign mem_rdata = (req_rd || req_wr) ? mem_word(req_addr) : '0;
  assign mem_err   = (req_rd || req_wr) && mem_bad(req_addr);

  // reference model state: request stage and result stage
  string m_tag, r_tag;
  int m_kind;   // 0 none 1 jump 2 call 3 ret 4 push 5 pop 6 bad
  logic [W-1:0] e_addr, e_wdata, m_sp, m_dest, m_npc;
  logic e_rd, e_wr, m_cond;
  logic [3:0] m_fn, m_rid;
  logic e_valid, e_spwe, e_pcwe, e_rgwe;
  logic [2:0] e_st;
  logic [W-1:0] e_sp, e_pc, e_rg;
  logic [3:0] e_rid;

  always @(posedge clk) begin
    if (rst) begin
      m_kind = 0; e_addr = 0; e_wdata = 0; e_rd = 0; e_wr = 0; m_tag = "R1";
      e_valid = 0; e_st = 0; e_spwe = 0; e_sp = 0; e_pcwe = 0; e_pc = 0;
      e_rgwe = 0; e_rid = 0; e_rg = 0; r_tag = "R1";
    end else begin
      logic bad, stk;
      logic [W-1:0] rd;
      rd  = mem_word(e_addr);
      stk = (m_kind >= 2 && m_kind <= 5);
      bad = stk && mem_bad(e_addr);
      r_tag = bad ? "R8" : m_tag;
      e_valid = (m_kind != 0);
      e_st = (m_kind == 0) ? 3'd0 : (m_kind == 6) ? 3'd4 : bad ? 3'd3 : 3'd1;
      e_spwe = 0; e_sp = 0; e_pcwe = 0; e_pc = 0; e_rgwe = 0; e_rid = 0; e_rg = 0;
      if (!bad) begin
        case (m_kind)
          1: begin e_pcwe = 1; e_pc = (m_fn == 0 || m_cond) ? m_dest : m_npc; end
          2: begin e_pcwe = 1; e_pc = m_dest; e_spwe = 1; e_sp = m_sp - 8; end
          3: begin e_pcwe = 1; e_pc = rd; e_spwe = 1; e_sp = m_sp + 8; end
          4: begin e_spwe = 1; e_sp = m_sp - 8; end
          5: begin
               e_spwe = 1;
               if (m_rid == 4'd4) e_sp = rd;
               else begin e_sp = m_sp + 8; e_rgwe = 1; e_rid = m_rid; e_rg = rd; end
             end
          default: ;
        endcase
      end
      // new request stage from the inputs
      m_sp = in_sp; m_dest = in_dest; m_npc = in_next_pc; m_cond = in_cond;
      m_fn = in_fn; m_rid = in_ra_id;
      e_addr = 0; e_wdata = 0; e_rd = 0; e_wr = 0;
      if (!in_valid) begin m_kind = 0; m_tag = "R10"; end
      else if (in_op == 4'h7 && in_fn <= 6) begin m_kind = 1; m_tag = "R7"; end
      else if (in_op >= 4'h8 && in_op <= 4'hB && in_fn == 0) begin
        m_kind = int'(in_op) - 6;
        case (in_op)
          4'h8: begin m_tag = "R5"; e_addr = in_sp - 8; e_wr = 1; e_wdata = in_next_pc; end
          4'h9: begin m_tag = "R6"; e_addr = in_sp; e_rd = 1; end
          4'hA: begin m_tag = "R2"; e_addr = in_sp - 8; e_wr = 1; e_wdata = in_ra_val; end
          default: begin m_tag = (in_ra_id == 4) ? "R4" : "R3"; e_addr = in_sp; e_rd = 1; end
        endcase
      end else begin m_kind = 6; m_tag = "R9"; end
    end
  end

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual %0d expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (!rst || cycles > 1) begin
      chk(m_tag, "req_rd", W'(req_rd), W'(e_rd));
      chk(m_tag, "req_wr", W'(req_wr), W'(e_wr));
      chk(m_tag, "req_addr", req_addr, e_addr);
      chk(m_tag, "req_wdata", req_wdata, e_wdata);
      chk(r_tag, "res_valid", W'(res_valid), W'(e_valid));
      chk(r_tag, "res_status", W'(res_status), W'(e_st));
      chk(r_tag, "res_sp_we", W'(res_sp_we), W'(e_spwe));
      chk(r_tag, "res_sp", res_sp, e_sp);
      chk(r_tag, "res_pc_we", W'(res_pc_we), W'(e_pcwe));
      chk(r_tag, "res_pc", res_pc, e_pc);
      chk(r_tag, "res_reg_we", W'(res_reg_we), W'(e_rgwe));
      chk(r_tag, "res_reg_id", W'(res_reg_id), W'(e_rid));
      chk(r_tag, "res_reg_data", res_reg_data, e_rg);
    end
  end

  task automatic issue(logic [3:0] op, logic [3:0] fn, logic [W-1:0] sp, logic [3:0] rid,
                       logic [W-1:0] rav, logic [W-1:0] dst, logic [W-1:0] npc, logic c);
    @(negedge clk);
    in_valid = 1; in_op = op; in_fn = fn; in_sp = sp; in_ra_id = rid;
    in_ra_val = rav; in_dest = dst; in_next_pc = npc; in_cond = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_op = 4'h7; in_fn = 0; in_sp = 64'h1234;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                                                      // R1 checked while idle
    idle(2);
    issue(4'hA, 0, 64'h200, 4'd3, 64'hDEAD_BEEF, 0, 0, 0);        // R2
    idle(2);
    issue(4'hB, 0, 64'h1F8, 4'd6, 0, 0, 0, 0);                    // R3
    issue(4'hB, 0, 64'h1F0, 4'd4, 0, 0, 0, 0);                    // R4 back to back (R11)
    issue(4'h8, 0, 64'h200, 4'd15, 0, 64'h62, 64'h57, 0);         // R5
    issue(4'h9, 0, 64'h1F8, 4'd15, 0, 0, 0, 0);                   // R6
    issue(4'h7, 0, 64'h200, 4'd15, 0, 64'h400, 64'h20, 0);        // R7 unconditional
    issue(4'h7, 3, 64'h200, 4'd15, 0, 64'h400, 64'h20, 1);        // R7 taken
    issue(4'h7, 3, 64'h200, 4'd15, 0, 64'h400, 64'h20, 0);        // R7 not taken
    issue(4'hA, 0, 64'h0, 4'd1, 64'h77, 0, 0, 0);                 // R8 wrap into bad region
    issue(4'hB, 0, 64'hF000_0000_0000_0010, 4'd2, 0, 0, 0, 0);    // R8 bad read
    issue(4'h9, 0, 64'hF000_0000_0000_0100, 4'd15, 0, 0, 0, 0);   // R8 bad ret
    issue(4'h5, 0, 64'h200, 4'd1, 0, 0, 0, 0);                    // R9 bad opcode
    issue(4'h7, 7, 64'h200, 4'd1, 0, 64'h99, 64'h10, 1);          // R9 bad jump fn
    issue(4'h8, 1, 64'h200, 4'd1, 0, 64'h99, 64'h10, 1);          // R9 call fn
    idle(3);
    for (int i = 0; i < 400; i++) begin                           // R11 random stream
      logic [3:0] op, fn;
      logic [W-1:0] sp;
      op = ($urandom % 8 == 0) ? 4'($urandom) : 4'(7 + $urandom % 5);
      fn = ($urandom % 6 == 0) ? 4'($urandom) : ((op == 4'h7) ? 4'($urandom % 7) : 4'd0);
      sp = {$urandom, $urandom};
      if ($urandom % 4 == 0) sp = 64'(($urandom % 4) * 8);
      if ($urandom % 5 == 0) begin
        idle(1);
      end else begin
        issue(op, fn, sp, 4'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, 1'($urandom));
      end
    end
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule